// File: doc/BRIEF.md
# Maskable Interrupt Request Controller with Priority Chain

This block gathers eight level-sensitive interrupt sources into a status register that is sampled on every clock. It ANDs that register with a mask that the CPU writes, and turns the result into a single open-drain, active-low interrupt request. The request is modelled as a pull-down enable: when the enable is high, the pin is pulled low. When the enable is low, the pin is released. The request stays active until every unmasked cause has gone away.

The block can also run in a vectored mode. In that mode, an interrupt acknowledge cycle returns a programmable vector byte on the data bus, even though chip select is inactive. Several such blocks can be wired in series through a priority chain built from enable-in and enable-out. A block blocks the devices further down the chain while it has a pending request. A block answers an acknowledge only when it has a pending request and its enable-in is high.

The CPU side uses a read strobe, a write strobe, chip select, a 3-bit address and an 8-bit data path. The data path is split into a write-data input, a read-data output and a drive enable. The drive enable stands for the bus leaving its high-impedance state.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, the mask register reads 0x00, the vector register reads 0x0F, the mode register reads 0x00, and the request pull-down enable is low.
- R2: The status register captures all eight source inputs on each clock. A read at address 0 returns these raw bits without the mask applied.
- R3: A read at address 1 returns the status register ANDed bitwise with the mask register.
- R4: The request pull-down enable is high exactly while the status register ANDed with the mask is non-zero. It drops once the last unmasked cause is cleared, even if masked causes remain.
- R5: A write takes effect on the first clock at which the write strobe is seen high after having been low, provided chip select is low at that clock. A strobe edge while chip select is high changes nothing.
- R6: Writes to address 0 and address 1 have no effect. The mask register and the status read-back stay the same.
- R7: When no acknowledge is being answered and chip select or the read strobe is high, the bus drive enable is low and the read data is 0x00.
- R8: The block answers an acknowledge when all of these hold: the acknowledge input is low, mode bit 0 is set, enable-in is high, and a masked cause is pending. When it answers, it drives the vector register onto the bus, whatever the state of chip select.
- R9: The block does not answer an acknowledge when mode bit 0 is clear, when enable-in is low, or when no masked cause is pending.
- R10: Enable-out is high only when enable-in is high and no masked cause is pending.
- R11: The address map for reads and writes is as follows: 2 is the mask register, 3 is the vector register, and 4 is the mode register, of which only bit 0 is stored. Reads at addresses 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src | input | 8 | Level-sensitive interrupt source conditions |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; a write commits on its rising edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| dout | output | 8 | Read or vector data; 0x00 when not driving |
| dout_en | output | 1 | Bus drive enable; low means high impedance |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| ien_in | input | 1 | Priority chain enable from the upstream device |
| ien_out | output | 1 | Priority chain enable to the downstream device |
| irq_pull | output | 1 | Pull-down enable for the open-drain interrupt request |

## Verification
A corrupted mask or status register appears at the request output, at enable-out and at the masked read-back on the next clock edge. A stuck mode bit or a wrong vector appears as soon as an acknowledge is presented. The bench runs a behavioural model alongside the design and compares every output on every clock, so any divergence is flagged within one cycle of its cause. Directed sequences cover the less common cases: a write strobe while chip select is high, writes to the read-only addresses, partial clearing of causes, and each reason to refuse an acknowledge.

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] src,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] dout,
  output logic       dout_en,
  input  logic       iack_n,
  input  logic       ien_in,
  output logic       ien_out,
  output logic       irq_pull
);

  localparam logic [2:0] A_RAW  = 3'd0;
  localparam logic [2:0] A_MSKD = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_VEC  = 3'd3;
  localparam logic [2:0] A_MODE = 3'd4;

  logic [7:0] stat_q, mask_q, vec_q, rd_mux;
  logic       mode_q, wr_q;

  wire wr_commit = !cs_n && !wr_q && wr_n;
  wire pend      = |(stat_q & mask_q);
  wire ack_hit   = mode_q && !iack_n && ien_in && pend;
  wire rd_hit    = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      vec_q  <= VEC_RST;
      mode_q <= 1'b0;
      wr_q   <= 1'b1;
    end else begin
      stat_q <= src;
      wr_q   <= wr_n;
      if (wr_commit) begin
        case (addr)
          A_MASK:  mask_q <= wdata;
          A_VEC:   vec_q  <= wdata;
          A_MODE:  mode_q <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_RAW:   rd_mux = stat_q;
      A_MSKD:  rd_mux = stat_q & mask_q;
      A_MASK:  rd_mux = mask_q;
      A_VEC:   rd_mux = vec_q;
      A_MODE:  rd_mux = {7'd0, mode_q};
      default: rd_mux = 8'h00;
    endcase
  end

  assign irq_pull = pend;
  assign ien_out  = ien_in && !pend;
  assign dout_en  = ack_hit || rd_hit;
  assign dout     = ack_hit ? vec_q : (rd_hit ? rd_mux : 8'h00);

  assert_status_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> stat_q == $past(src));

  assert_req_needs_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> (mask_q != 8'h00) && (stat_q != 8'h00));

  assert_no_write_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $rose(wr_n)) |=> $stable(mask_q) && $stable(vec_q) && $stable(mode_q));

  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && iack_n) |-> !dout_en);

  assert_ack_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && (!ien_in || !mode_q)) |-> !dout_en);

  assert_chain_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_in || irq_pull) |-> !ien_out);

endmodule

// File: tb/test_irq_chain_ctrl.sv
module test_irq_chain_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [7:0] src = 0, wdata = 0;
  logic       cs_n = 1, rd_n = 1, wr_n = 1, iack_n = 1, ien_in = 1;
  logic [2:0] addr = 0;
  logic [7:0] dout;
  logic       dout_en, ien_out, irq_pull;

  int tests = 0, fails = 0;
  bit cmp_on = 0;

  irq_chain_ctrl i_irq_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .src(src), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .dout(dout), .dout_en(dout_en), .iack_n(iack_n),
    .ien_in(ien_in), .ien_out(ien_out), .irq_pull(irq_pull));

  always #5 clk = ~clk;

  logic [7:0] m_stat, m_mask, m_vec;
  bit m_mode, m_wrprev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_vec = 8'h0F; m_mode = 0; m_wrprev = 1;
    end else begin
      if (!cs_n && !m_wrprev && wr_n) begin
        if (addr == 2) m_mask = wdata;
        else if (addr == 3) m_vec = wdata;
        else if (addr == 4) m_mode = wdata[0];
      end
      m_stat = src;
      m_wrprev = wr_n;
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      0: return m_stat;
      1: return m_stat & m_mask;
      2: return m_mask;
      3: return m_vec;
      4: return {7'd0, m_mode};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    bit pend, ack, rd;
    pend = (m_stat & m_mask) != 0;
    ack  = !iack_n && m_mode && ien_in && pend;
    rd   = !cs_n && !rd_n;
    check("R4 request", irq_pull, pend);
    check("R10 chain out", ien_out, ien_in && !pend);
    check(ack ? "R8 drive" : (rd ? "R11 drive" : "R7 drive"), dout_en, ack || rd);
    check(ack ? "R8 vector" : (rd ? "R11 data" : "R7 data"), dout,
          ack ? m_vec : (rd ? m_read(addr) : 8'h00));
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit sel);
    cyc(1); cs_n = !sel; addr = a; wdata = d; wr_n = 0;
    cyc(1); wr_n = 1;
    cyc(1); cs_n = 1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    cyc(1); cs_n = 0; rd_n = 0; addr = a;
    @(negedge clk);
    check(tag, dout, exp);
    check(tag, dout_en, 1);
    cyc(1); cs_n = 1; rd_n = 1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cmp_on = 1;
    @(negedge clk);
    check("R1 request idle", irq_pull, 0);
    check("R1 bus idle", dout_en, 0);
    rd(2, 8'h00, "R1 mask reset");
    rd(3, 8'h0F, "R1 vector reset");
    rd(4, 8'h00, "R1 mode reset");

    src = 8'hA5; cyc(2);
    rd(0, 8'hA5, "R2 raw status");
    rd(1, 8'h00, "R3 masked all off");
    check("R4 masked no request", irq_pull, 0);

    wr(2, 8'h05, 1);
    rd(1, 8'h05, "R3 masked view");
    @(negedge clk);
    check("R4 request on", irq_pull, 1);
    check("R10 chain blocked", ien_out, 0);

    wr(2, 8'hFF, 0);
    rd(2, 8'h05, "R5 unselected write ignored");
    wr(0, 8'hFF, 1); wr(1, 8'h00, 1);
    rd(2, 8'h05, "R6 ro write mask kept");
    rd(0, 8'hA5, "R6 ro write raw kept");

    cyc(1); iack_n = 0; @(negedge clk);
    check("R9 mode off no ack", dout_en, 0);
    cyc(1); iack_n = 1;

    wr(4, 8'h01, 1); wr(3, 8'h3C, 1);
    rd(4, 8'h01, "R11 mode read");
    cyc(1); iack_n = 0; @(negedge clk);
    check("R8 ack drive", dout_en, 1);
    check("R8 ack vector", dout, 8'h3C);
    cyc(1); ien_in = 0; @(negedge clk);
    check("R9 chain low no ack", dout_en, 0);
    check("R10 chain low", ien_out, 0);
    cyc(1); ien_in = 1;

    src = 8'hA1; cyc(2); @(negedge clk);
    check("R4 partial clear holds", irq_pull, 1);
    src = 8'hA0; cyc(2); @(negedge clk);
    check("R4 all clear releases", irq_pull, 0);
    check("R9 nothing pending no ack", dout_en, 0);
    check("R10 chain passes", ien_out, 1);
    cyc(1); iack_n = 1;

    wr(2, 8'hF0, 1); cyc(1);
    rd(1, 8'hA0, "R3 upper mask");
    rd(5, 8'h00, "R11 unused addr");
    rd(7, 8'h00, "R11 unused addr top");

    cyc(1); cs_n = 1; rd_n = 0; addr = 2; @(negedge clk);
    check("R7 unselected read quiet", dout_en, 0);
    check("R7 unselected data zero", dout, 0);
    cyc(1); rd_n = 1;

    for (int k = 0; k < 16; k++) begin
      src = 8'(k * 37); cyc(1);
    end
    cyc(2);
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule